// File: doc/BRIEF.md
# Variable-Width FIFO SPI Master

This block is an SPI master on a 32-bit register bus. Software fills a four-entry transmit queue. Each queued word carries its own shift length and a payload of up to 24 bits, so short and odd-sized transfers take no extra configuration writes. Every shifted entry leaves a right-aligned word in a four-entry receive queue. The store address chosen for an entry decides whether the chip select is released after it or stays asserted so that the next entry continues the same frame.

One configuration register sets the clock divider, the idle clock level, the SCK edge that launches data, the edge that samples it, the output bit order, an enable and the chip-select lines to drive. A second register sets the input bit order and two interrupt enables. A status word reports queue levels, full and empty flags, busy and the bit counter. Bus reads return data one cycle after the request.

Top module: `spim_top`

## Requirements
- R1: After reset `cs_n` is 3'b111, `sck` is 0, `irq` is 0 and the status word (offset 0x08) reads 0x00000280, which means both queues are empty and the engine is not busy.
- R2: With divider field D in configuration bits 31:20, one SCK period lasts 2*(D+1) system clocks. Each half period lasts D+1 clocks. While no bit is being shifted, `sck` rests at the idle level set by configuration bit 7.
- R3: When configuration bit 14 is 1, the length is taken from entry bits 31:24. When bit 14 is 0, the length is taken from configuration bits 5:0. A length of 0 is treated as 1 and a length above 24 is treated as 24. An entry produces exactly that many SCK pulses.
- R4: When configuration bit 6 is 1, the payload goes out from entry bit 23 downwards. When bit 6 is 0, it goes out from entry bit 0 upwards.
- R5: Each finished entry pushes its received bits into the receive queue, right-aligned and zero-extended. When register bit 1 at offset 0x04 is 1, the first received bit lands in the most significant position of the word. When that bit is 0, the first received bit lands in bit 0. A read of offset 0x20 pops the queue. A read of offset 0x0C returns the head entry without popping. A read of an empty queue returns 0.
- R6: Configuration bit 10 (sample on rising edge) and bit 8 (launch on rising edge) select the sampling edge and the launching edge. When the two edges differ, a loopback from `mosi` to `miso` returns the transmitted bits.
- R7: An entry written at offset 0x20 releases chip select exactly one SCK period after its last clock edge. An entry written at offset 0x30 keeps chip select asserted, including while the queue is empty, until a later entry releases it.
- R8: After the last bit of an entry, `sck` stays idle for at least two SCK periods before the next entry starts.
- R9: Chip select is active low. While a transfer is in progress, bit i of `cs_n` is low exactly when bit 17+i of the configuration is set.
- R10: Each queue holds 4 entries. A store to a full transmit queue is dropped. The status word reports the transmit level in bits 31:24, the receive level in bits 23:16, and the flags transmit full (bit 10), transmit empty (bit 9), receive full (bit 8), receive empty (bit 7) and busy (bit 6).
- R11: Writing configuration bit 9 as 1 empties both queues in that cycle, stops the shifter and releases chip select. Bit 9 reads back as 0.
- R12: `irq` is the OR of two terms: transmit queue empty gated by bit 7 at offset 0x04, and engine idle gated by bit 6 at offset 0x04.
- R13: While configuration bit 11 (enable) is 0, queued entries wait and no SCK pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
The serial path runs as a loopback from `mosi` to `miso` under random lengths, payloads, divider values, both bit orders in each direction, and all four combinations of idle level and edge choice in which the launch edge differs from the sample edge. A wrong bit order, a wrong edge or a wrong count shows up as a mismatch against a reference word that the bench folds itself. Directed runs cover the following cases:
- the fixed-length mode and the clamping of lengths of 0 and 40;
- a held entry followed by a released one, told apart by counting chip-select rises and timing the rise and the inter-entry gap;
- a full queue with a dropped fifth store;
- peek against pop;
- a clear issued both while entries are queued and during a transfer;
- each interrupt enable on its own.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [5:0] A_CFG  = 6'h00;
  localparam logic [5:0] A_IEN  = 6'h04;
  localparam logic [5:0] A_STAT = 6'h08;
  localparam logic [5:0] A_PEEK = 6'h0C;
  localparam logic [5:0] A_DATA = 6'h20;
  localparam logic [5:0] A_HOLD = 6'h30;

  localparam int unsigned MAX_BITS = 24;
  localparam int unsigned DIV_W    = 12;
  localparam int unsigned B_CLR    = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_GAP} eng_st_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [2:0]       csel;
    logic             varw;
    logic             en;
    logic             in_rise;
    logic             out_rise;
    logic             cpol;
    logic             msb_out;
    logic [5:0]       flen;
  } cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  assert_drop_when_full_R10: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (level == $past(level)));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  input  logic             varw,
  input  logic [5:0]       flen,
  input  logic             en,
  input  logic             in_rise,
  input  logic             out_rise,
  input  logic             cpol,
  input  logic             msb_out,
  input  logic             msb_in,
  input  logic             ent_valid,
  input  logic [31:0]      ent_word,
  input  logic             ent_hold,
  output logic             ent_pop,
  input  logic             miso,
  output logic             rx_push,
  output logic [MAX_BITS-1:0] rx_word,
  output logic             sck,
  output logic             mosi,
  output logic             cs_act,
  output logic             busy,
  output logic [5:0]       bit_cnt
);
  eng_st_t              st;
  logic [DIV_W-1:0]     dcnt;
  logic                 half, hold_q, sck_q, mosi_q, cs_q;
  logic [4:0]           k, n, len_eff;
  logic [1:0]           gcnt;
  logic [MAX_BITS-1:0]  w, rsh, cap, rx_nxt;
  logic [7:0]           len_raw;
  logic                 tick, mid_rise, launch_mid, sample_mid, sample_now;

  function automatic logic pick(input logic [MAX_BITS-1:0] v, input logic [4:0] i,
                                input logic msbf);
    return msbf ? v[5'(MAX_BITS-1) - i] : v[i];
  endfunction

  assign tick       = (dcnt == div);
  assign mid_rise   = ~cpol;
  assign launch_mid = (out_rise == mid_rise);
  assign sample_mid = (in_rise == mid_rise);
  assign len_raw    = varw ? ent_word[31:24] : {2'b00, flen};

  always_comb begin
    if (len_raw == 8'd0)                 len_eff = 5'd1;
    else if (len_raw > 8'(MAX_BITS))     len_eff = 5'(MAX_BITS);
    else                                 len_eff = len_raw[4:0];
  end

  assign sample_now = (st == ST_BITS) && tick && (half ? !sample_mid : sample_mid);
  assign cap     = msb_in ? {rsh[MAX_BITS-2:0], miso} : (rsh | (MAX_BITS'(miso) << k));
  assign rx_nxt  = sample_now ? cap : rsh;
  assign rx_push = (st == ST_BITS) && tick && half && (k == n - 5'd1) && !clr;
  assign rx_word = rx_nxt;
  assign ent_pop = (st == ST_IDLE) && en && ent_valid && !clr;
  assign busy    = (st != ST_IDLE);
  assign bit_cnt = busy ? {1'b0, k} : 6'd0;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign cs_act  = cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; dcnt <= '0; half <= 1'b0; k <= '0; n <= 5'd1;
      w <= '0; rsh <= '0; hold_q <= 1'b0; gcnt <= '0; cs_q <= 1'b0;
      sck_q <= 1'b0; mosi_q <= 1'b0;
    end else if (clr) begin
      st <= ST_IDLE; dcnt <= '0; half <= 1'b0; k <= '0; gcnt <= '0;
      cs_q <= 1'b0; sck_q <= cpol; mosi_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          sck_q <= cpol;
          dcnt  <= '0;
          if (ent_pop) begin
            st     <= ST_BITS;
            w      <= ent_word[MAX_BITS-1:0];
            n      <= len_eff;
            hold_q <= ent_hold;
            k      <= '0;
            half   <= 1'b0;
            rsh    <= '0;
            cs_q   <= 1'b1;
            mosi_q <= pick(ent_word[MAX_BITS-1:0], 5'd0, msb_out);
          end
        end
        ST_BITS: begin
          dcnt <= tick ? '0 : dcnt + 1'b1;
          rsh  <= rx_nxt;
          if (tick) begin
            if (!half) begin
              half  <= 1'b1;
              sck_q <= ~cpol;
              if (launch_mid) mosi_q <= pick(w, k, msb_out);
            end else begin
              half  <= 1'b0;
              sck_q <= cpol;
              if (k == n - 5'd1) begin
                st   <= ST_GAP;
                gcnt <= '0;
                k    <= n;
              end else begin
                k <= k + 5'd1;
                if (!launch_mid) mosi_q <= pick(w, k + 5'd1, msb_out);
              end
            end
          end
        end
        ST_GAP: begin
          sck_q <= cpol;
          dcnt  <= tick ? '0 : dcnt + 1'b1;
          if (tick) begin
            gcnt <= gcnt + 2'd1;
            if (gcnt == 2'd1 && !hold_q) cs_q <= 1'b0;
            if (gcnt == 2'd3) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_cs_in_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BITS) |-> cs_q);
  assert_sck_rest_R2: assert property (@(posedge clk) disable iff (rst || clr)
    (st != ST_BITS) |=> (sck_q == $past(cpol)));
  assert_gap_follows_R8: assert property (@(posedge clk) disable iff (rst || clr)
    rx_push |=> (st == ST_GAP));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BITS) |-> (k < n));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  cs_n,
  output logic        irq
);
  localparam int LW = $clog2(FIFO_DEPTH+1);

  cfg_t  cfg;
  logic  ie_txe, ie_idle, msb_in;
  logic  wr, rd, clr;
  logic  tx_push, tx_pop, tx_full, tx_empty, tx_hold;
  logic  [31:0] tx_word;
  logic  [LW-1:0] tx_lvl, rx_lvl;
  logic  rx_push, rx_pop, rx_full, rx_empty;
  logic  [MAX_BITS-1:0] rx_in, rx_head;
  logic  cs_act, busy;
  logic  [5:0] bit_cnt;
  logic  [31:0] stat_w, cfg_w, ien_w;

  assign wr      = bus_sel && bus_wr;
  assign rd      = bus_sel && !bus_wr;
  assign clr     = wr && (bus_addr == A_CFG) && bus_wdata[B_CLR];
  assign tx_push = wr && ((bus_addr == A_DATA) || (bus_addr == A_HOLD));
  assign rx_pop  = rd && (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0; ie_txe <= 1'b0; ie_idle <= 1'b0; msb_in <= 1'b0;
    end else if (wr && bus_addr == A_CFG) begin
      cfg.div      <= bus_wdata[31:20];
      cfg.csel     <= bus_wdata[19:17];
      cfg.varw     <= bus_wdata[14];
      cfg.en       <= bus_wdata[11];
      cfg.in_rise  <= bus_wdata[10];
      cfg.out_rise <= bus_wdata[8];
      cfg.cpol     <= bus_wdata[7];
      cfg.msb_out  <= bus_wdata[6];
      cfg.flen     <= bus_wdata[5:0];
    end else if (wr && bus_addr == A_IEN) begin
      ie_txe  <= bus_wdata[7];
      ie_idle <= bus_wdata[6];
      msb_in  <= bus_wdata[1];
    end
  end

  spim_fifo #(.W(33), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(clr), .push(tx_push),
    .din({bus_addr == A_HOLD, bus_wdata}), .pop(tx_pop),
    .dout({tx_hold, tx_word}), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(clr), .push(rx_push), .din(rx_in), .pop(rx_pop),
    .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  spim_engine u_eng (
    .clk(clk), .rst(rst), .clr(clr), .div(cfg.div), .varw(cfg.varw), .flen(cfg.flen),
    .en(cfg.en), .in_rise(cfg.in_rise), .out_rise(cfg.out_rise), .cpol(cfg.cpol),
    .msb_out(cfg.msb_out), .msb_in(msb_in), .ent_valid(!tx_empty), .ent_word(tx_word),
    .ent_hold(tx_hold), .ent_pop(tx_pop), .miso(miso), .rx_push(rx_push),
    .rx_word(rx_in), .sck(sck), .mosi(mosi), .cs_act(cs_act), .busy(busy),
    .bit_cnt(bit_cnt));

  assign cs_n   = ~({3{cs_act}} & cfg.csel);
  assign stat_w = {8'(tx_lvl), 8'(rx_lvl), 5'b0, tx_full, tx_empty, rx_full, rx_empty,
                   busy, bit_cnt};
  assign cfg_w  = {cfg.div, cfg.csel, 2'b0, cfg.varw, 2'b0, cfg.en, cfg.in_rise, 1'b0,
                   cfg.out_rise, cfg.cpol, cfg.msb_out, cfg.flen};
  assign ien_w  = {24'b0, ie_txe, ie_idle, 4'b0, msb_in, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= (ie_txe && tx_empty) || (ie_idle && !busy);
      if (rd) begin
        unique case (bus_addr)
          A_CFG:   bus_rdata <= cfg_w;
          A_IEN:   bus_rdata <= ien_w;
          A_STAT:  bus_rdata <= stat_w;
          A_PEEK:  bus_rdata <= rx_empty ? 32'd0 : 32'(rx_head);
          A_DATA:  bus_rdata <= rx_empty ? 32'd0 : 32'(rx_head);
          default: bus_rdata <= 32'd0;
        endcase
      end
    end
  end

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (bus_rdata == 32'd0));
  assert_clear_releases_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cs_n == 3'b111 && !busy));
endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam real CLKP = 5.0;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck, mosi, miso;
  logic [2:0]  cs_n;
  logic        irq;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign miso = mosi;

  spim_top u0 (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq));

  int      tog = 0, cs_rises = 0;
  realtime last_t = 0, maxgap = 0, cs_rise_t = 0;
  always @(sck) begin
    if (tog > 0 && ($realtime - last_t) > maxgap) maxgap = $realtime - last_t;
    last_t = $realtime;
    tog++;
  end
  always @(posedge cs_n[0]) begin
    cs_rise_t = $realtime;
    cs_rises++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    forever begin
      rd(6'h08, s);
      if (!s[6] && s[31:24] == 8'd0) break;
    end
  endtask

  task automatic zero_mon();
    repeat (2) @(negedge clk);
    tog = 0; maxgap = 0; cs_rises = 0;
  endtask

  function automatic logic [31:0] mkcfg(input int s, input logic [2:0] cs, input logic vw,
      input logic en, input logic inr, input logic outr, input logic cp, input logic mo,
      input logic [5:0] fl);
    return (32'(s) << 20) | (32'(cs) << 17) | (32'(vw) << 14) | (32'(en) << 11) |
           (32'(inr) << 10) | (32'(outr) << 8) | (32'(cp) << 7) | (32'(mo) << 6) | 32'(fl);
  endfunction

  function automatic logic [31:0] ref_rx(input logic [23:0] w, input int n,
                                         input logic mo, input logic mi);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) begin
      logic b = mo ? w[23-i] : w[i];
      if (mi) r = (r << 1) | 32'(b);
      else    r = r | (32'(b) << i);
    end
    return r;
  endfunction

  function automatic int eff_len(input int raw);
    return (raw == 0) ? 1 : ((raw > 24) ? 24 : raw);
  endfunction

  initial begin
    #(CLKP * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    int s, m, n, lens[4];
    logic cp, inr, outr, mo, mi;
    logic [23:0] dat;
    logic [23:0] fifo_dat[4];
    void'($urandom(32'd917));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'h7);
    chk("R1 sck", 32'(sck), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(6'h08, d); chk("R1 status", d, 32'h0000_0280);

    // R2 R3 R4 R5 R6: random loopback
    for (int it = 0; it < 36; it++) begin
      s = int'($urandom % 4); m = int'($urandom % 4);
      mo = 1'($urandom); mi = 1'($urandom);
      n = 1 + int'($urandom % 24); dat = 24'($urandom);
      unique case (m)
        0: begin cp = 0; inr = 1; outr = 0; end
        1: begin cp = 1; inr = 0; outr = 1; end
        2: begin cp = 0; inr = 0; outr = 1; end
        default: begin cp = 1; inr = 1; outr = 0; end
      endcase
      wr(6'h04, {30'b0, mi, 1'b0});
      wr(6'h00, mkcfg(s, 3'b001, 1, 1, inr, outr, cp, mo, 6'd0));
      zero_mon();
      wr(6'h20, {8'(n), dat});
      wait_done();
      rd(6'h20, d);
      chk($sformatf("R4 R5 R6 loopback it%0d", it), d, ref_rx(dat, n, mo, mi));
      chk("R3 pulse count", 32'(tog / 2), 32'(n));
      chk("R2 half period", 32'(int'(maxgap / CLKP)), 32'(s + 1));
      chk("R2 idle level", 32'(sck), 32'(cp));
    end

    // R3 fixed-length mode and clamping
    wr(6'h04, 32'h2);
    wr(6'h00, mkcfg(0, 3'b001, 0, 1, 1, 0, 0, 1, 6'd5));
    zero_mon(); wr(6'h20, 32'hFF_ABCDEF); wait_done(); rd(6'h20, d);
    chk("R3 fixed len count", 32'(tog / 2), 32'd5);
    chk("R3 fixed len data", d, ref_rx(24'hABCDEF, 5, 1, 1));
    wr(6'h00, mkcfg(0, 3'b001, 1, 1, 1, 0, 0, 1, 6'd5));
    zero_mon(); wr(6'h20, 32'h00_800000); wait_done(); rd(6'h20, d);
    chk("R3 clamp zero", 32'(tog / 2), 32'(eff_len(0)));
    zero_mon(); wr(6'h20, 32'h28_5A5A5A); wait_done(); rd(6'h20, d);
    chk("R3 clamp high", 32'(tog / 2), 32'(eff_len(40)));
    chk("R3 clamp high data", d, 32'h5A5A5A);

    // R7 R8: two released entries
    s = 1;
    wr(6'h00, mkcfg(s, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0));
    wr(6'h20, 32'h08_C30000); wr(6'h20, 32'h08_3C0000);
    zero_mon();
    wr(6'h00, mkcfg(s, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0));
    wait_done(); repeat (4) @(negedge clk);
    chk("R7 released rises", 32'(cs_rises), 32'd2);
    chk("R7 release delay", 32'(int'((cs_rise_t - last_t) / CLKP)), 32'(2 * (s + 1)));
    chk("R8 gap", 32'(maxgap >= CLKP * 4 * (s + 1)), 32'd1);
    rd(6'h20, d); chk("R5 first", d, 32'hC3);
    rd(6'h20, d); chk("R5 second", d, 32'h3C);

    // R7: held entry then released entry
    wr(6'h00, mkcfg(s, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0));
    wr(6'h30, 32'h08_110000); wr(6'h20, 32'h08_220000);
    zero_mon();
    wr(6'h00, mkcfg(s, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0));
    wait_done(); repeat (4) @(negedge clk);
    chk("R7 held rises", 32'(cs_rises), 32'd1);
    chk("R8 held gap", 32'(maxgap >= CLKP * 4 * (s + 1)), 32'd1);
    rd(6'h20, d); rd(6'h20, d);
    zero_mon(); wr(6'h30, 32'h04_F00000); wait_done(); repeat (8) @(negedge clk);
    chk("R7 held with empty queue", 32'(cs_n[0]), 32'd0);
    wr(6'h20, 32'h04_F00000); wait_done(); repeat (8) @(negedge clk);
    chk("R7 later release", 32'(cs_n[0]), 32'd1);
    rd(6'h20, d); rd(6'h20, d);

    // R9 chip select lines
    wr(6'h00, mkcfg(3, 3'b101, 1, 1, 1, 0, 0, 1, 6'd0));
    wr(6'h20, 32'h18_123456);
    repeat (20) @(negedge clk);
    chk("R9 active lines", 32'(cs_n), 32'h2);
    wait_done(); repeat (10) @(negedge clk);
    chk("R9 released lines", 32'(cs_n), 32'h7);
    rd(6'h20, d);

    // R10 R13 full queue and enable
    wr(6'h00, mkcfg(0, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0));
    zero_mon();
    for (int i = 0; i < 5; i++) begin
      dat = 24'($urandom);
      if (i < 4) fifo_dat[i] = dat;
      wr(6'h20, {8'd8, dat});
    end
    repeat (10) @(negedge clk);
    rd(6'h08, d);
    chk("R10 tx level", 32'(d[31:24]), 32'd4);
    chk("R10 tx full", 32'(d[10]), 32'd1);
    chk("R13 no pulses while disabled", 32'(tog), 32'd0);
    chk("R13 not busy while disabled", 32'(d[6]), 32'd0);
    wr(6'h00, mkcfg(0, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0));
    wait_done();
    rd(6'h08, d);
    chk("R10 rx level", 32'(d[23:16]), 32'd4);
    chk("R10 rx full", 32'(d[8]), 32'd1);
    rd(6'h0C, d); rd(6'h0C, e);
    chk("R5 peek head", d, ref_rx(fifo_dat[0], 8, 1, 1));
    chk("R5 peek stable", e, d);
    rd(6'h08, d); chk("R5 peek no pop", 32'(d[23:16]), 32'd4);
    for (int i = 0; i < 4; i++) begin
      rd(6'h20, d);
      chk($sformatf("R10 kept entry %0d", i), d, ref_rx(fifo_dat[i], 8, 1, 1));
    end
    rd(6'h20, d); chk("R5 empty read", d, 32'd0);
    rd(6'h08, d); chk("R10 rx empty flag", 32'(d[7]), 32'd1);

    // R11 clear with queued entries, an unread rx word, and mid-transfer
    wr(6'h20, 32'h08_AA0000); wait_done();
    wr(6'h00, mkcfg(0, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0));
    wr(6'h20, 32'h08_010000); wr(6'h20, 32'h08_020000);
    wr(6'h00, mkcfg(0, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0) | 32'h200);
    rd(6'h08, d); chk("R11 queues emptied", d, 32'h0000_0280);
    rd(6'h00, d); chk("R11 clear bit reads zero", 32'(d[9]), 32'd0);
    wr(6'h00, mkcfg(3, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0));
    wr(6'h30, 32'h18_FFFFFF);
    repeat (30) @(negedge clk);
    chk("R11 pre-clear cs", 32'(cs_n[0]), 32'd0);
    wr(6'h00, mkcfg(3, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0) | 32'h200);
    chk("R11 cs released", 32'(cs_n), 32'h7);
    rd(6'h08, d); chk("R11 idle after clear", d, 32'h0000_0280);

    // R12 interrupts
    wr(6'h04, 32'h0); repeat (3) @(negedge clk);
    chk("R12 none enabled", 32'(irq), 32'd0);
    wr(6'h00, mkcfg(3, 3'b001, 1, 0, 1, 0, 0, 1, 6'd0));
    wr(6'h20, 32'h18_0F0F0F);
    wr(6'h04, 32'h80); repeat (3) @(negedge clk);
    chk("R12 txe with queued entry", 32'(irq), 32'd0);
    wr(6'h04, 32'h40); repeat (3) @(negedge clk);
    chk("R12 idle enabled and idle", 32'(irq), 32'd1);
    wr(6'h00, mkcfg(3, 3'b001, 1, 1, 1, 0, 0, 1, 6'd0));
    repeat (20) @(negedge clk);
    chk("R12 idle enabled and busy", 32'(irq), 32'd0);
    wr(6'h04, 32'h80); repeat (3) @(negedge clk);
    chk("R12 txe with empty queue", 32'(irq), 32'd1);
    wait_done();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule